// File: doc/BRIEF.md
# Hot-Swap Two-Wire Bus Connection Supervisor

This controller decides when the backplane side of a two-wire serial bus (data and clock lines) may be joined to the bus on a plug-in card. It samples the two backplane lines and the two card lines as logic levels through two-flop synchronizers. After power becomes good, or after the enable input is raised, it waits until the backplane traffic reaches a boundary and the card lines are released. The boundary is either a STOP condition or a quiet period on both lines. It then turns the link on. The analog pass devices act on the link output, and an enable goes to the rise-time accelerators.

While the link is being qualified or is on, a stuck-low timer watches the card side. If either card line stays low for the timeout period, the link is broken. After a short pause, the controller pulls the card clock low in a bounded burst of recovery pulses. The burst ends early once the card data line is seen high. Reconnection then follows the normal qualification. Raising the enable input after such a fault forces the link on at once, and the timer stays armed. All periods are parameters counted in clock cycles.

Top module: `hs_bus_guard`

## Requirements
- R1: While `rst_n` is low or `pwr_ok` is low, `bridge_on`, `ready`, `accel_en` and `card_scl_pull` are all 0, and all timers and the fault memory are cleared.
- R2: With `pwr_ok` and `enable` high and both card lines high, the link turns on once both backplane lines have been high for IDLE_CYC consecutive sampled cycles. A newly raised `enable` with no fault pending also waits for this idle period.
- R3: A STOP condition on the synchronized backplane lines turns the link on without waiting for the idle period. A STOP is the data line going from 0 to 1 while the clock line is 1 in both samples.
- R4: The link never turns on through qualification while either card line is low. A STOP or idle seen earlier is remembered, and the link turns on once both card lines are high.
- R5: `bridge_on`, `ready` and `accel_en` are 1 exactly while the link is on.
- R6: While the link is on or being qualified, a card line that stays low for STUCK_CYC cycles turns the link off. Both card lines high at the same time clears the timer.
- R7: After a timeout, `card_scl_pull` stays 0 for GAP_CYC cycles. It then makes up to NPULSE pulses, each HALF_CYC cycles at 1 followed by HALF_CYC cycles at 0, and `accel_en` is 0 throughout.
- R8: At the end of each pulse, the burst stops if the synchronized card data line is 1. `card_scl_pull` is 0 when the burst ends.
- R9: After a burst ends, the link turns on again through the same qualification as R2 to R4. If the card bus is still stuck, another timeout and burst follow.
- R10: If `pwr_ok` rises while a card line is held low, the link stays off. Recovery pulses begin STUCK_CYC + GAP_CYC cycles later.
- R11: `enable` low turns the link off from the next cycle and stops or prevents any recovery burst.
- R12: A rising edge on `enable` after a timeout fault turns the link on within two cycles, even with the card bus still low. The stuck timer restarts from zero and can time out again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_ok | input | 1 | Supply above lockout threshold |
| enable | input | 1 | Connection enable (synchronous) |
| bp_sda | input | 1 | Backplane data line level |
| bp_scl | input | 1 | Backplane clock line level |
| card_sda | input | 1 | Card data line level |
| card_scl | input | 1 | Card clock line level |
| bridge_on | output | 1 | Link active, closes the pass devices |
| ready | output | 1 | Connection status flag |
| accel_en | output | 1 | Rise-time accelerator enable |
| card_scl_pull | output | 1 | Request to pull the card clock low |

## Verification
The bound checker checks four things on every cycle. Recovery pulses never coincide with an active link or the accelerators. Loss of power or enable clears the link and the pulses by the next cycle. Every link turn-on is preceded either by both card lines high or by an enable edge. The bench scenarios cover the rest: the idle and STOP qualification times, the exact gap and pulse width, the early stop after each possible number of pulses, the full burst on a bus that never frees, power-up into a stuck bus, and the forced connection with its re-armed timer.

// File: rtl/hs_bus_guard.sv
module hs_bus_guard #(
  parameter int IDLE_CYC  = 4750,
  parameter int STUCK_CYC = 1500000,
  parameter int GAP_CYC   = 2000,
  parameter int HALF_CYC  = 2941,
  parameter int NPULSE    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic enable,
  input  logic bp_sda,
  input  logic bp_scl,
  input  logic card_sda,
  input  logic card_scl,
  output logic bridge_on,
  output logic ready,
  output logic accel_en,
  output logic card_scl_pull
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam int SW = $clog2(STUCK_CYC + 1);
  localparam int TMAX = (GAP_CYC > 2 * HALF_CYC) ? GAP_CYC : 2 * HALF_CYC;
  localparam int TW = $clog2(TMAX + 1);
  localparam int PW = $clog2(NPULSE + 1);

  typedef enum logic [1:0] {S_WAIT, S_LINK, S_GAP, S_CLK} st_t;
  st_t st;

  logic [3:0] m1, m2;
  logic prev_sda, prev_scl, en_q, fault, qual;
  logic [IW-1:0] idle_cnt;
  logic [SW-1:0] stuck_cnt;
  logic [TW-1:0] tmr;
  logic [PW-1:0] npulse;

  wire b_sda   = m2[3];
  wire b_scl   = m2[2];
  wire c_sda   = m2[1];
  wire c_scl   = m2[0];
  wire card_hi = c_sda & c_scl;
  wire en_rise = enable & ~en_q;
  wire stop    = b_scl & prev_scl & b_sda & ~prev_sda;
  wire idle_ok = (idle_cnt == IW'(IDLE_CYC));
  wire watch   = (st == S_WAIT) || (st == S_LINK);
  wire timeout = watch && !card_hi && (stuck_cnt == SW'(STUCK_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; prev_sda <= 1'b0; prev_scl <= 1'b0; en_q <= 1'b0;
      st <= S_WAIT; fault <= 1'b0; qual <= 1'b0;
      idle_cnt <= '0; stuck_cnt <= '0; tmr <= '0; npulse <= '0;
    end else begin
      m1 <= {bp_sda, bp_scl, card_sda, card_scl};
      m2 <= m1;
      prev_sda <= b_sda;
      prev_scl <= b_scl;
      en_q <= enable;
      if (!pwr_ok || !enable) begin
        st <= S_WAIT; qual <= 1'b0; idle_cnt <= '0; stuck_cnt <= '0;
        tmr <= '0; npulse <= '0;
        if (!pwr_ok) fault <= 1'b0;
      end else if (en_rise && fault) begin
        st <= S_LINK; fault <= 1'b0; qual <= 1'b0; stuck_cnt <= '0;
      end else begin
        if (b_sda && b_scl) idle_cnt <= idle_ok ? idle_cnt : idle_cnt + 1'b1;
        else idle_cnt <= '0;
        if (card_hi || !watch) stuck_cnt <= '0;
        else stuck_cnt <= stuck_cnt + 1'b1;
        unique case (st)
          S_WAIT:
            if (timeout) begin
              st <= S_GAP; fault <= 1'b1; qual <= 1'b0; tmr <= '0;
            end else if ((qual || stop || idle_ok) && card_hi) begin
              st <= S_LINK; qual <= 1'b0; fault <= 1'b0;
            end else if (stop || idle_ok) qual <= 1'b1;
          S_LINK:
            if (timeout) begin
              st <= S_GAP; fault <= 1'b1; tmr <= '0;
            end
          S_GAP:
            if (tmr == TW'(GAP_CYC - 1)) begin
              st <= S_CLK; tmr <= '0; npulse <= '0;
            end else tmr <= tmr + 1'b1;
          S_CLK:
            if (tmr == TW'(2 * HALF_CYC - 1)) begin
              tmr <= '0;
              if (c_sda || npulse == PW'(NPULSE - 1)) st <= S_WAIT;
              else npulse <= npulse + 1'b1;
            end else tmr <= tmr + 1'b1;
          default: st <= S_WAIT;
        endcase
      end
    end
  end

  assign bridge_on     = (st == S_LINK);
  assign ready         = bridge_on;
  assign accel_en      = bridge_on;
  assign card_scl_pull = (st == S_CLK) && (tmr < TW'(HALF_CYC));
endmodule

// File: rtl/hs_bus_guard_chk.sv
module hs_bus_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok,
  input logic enable,
  input logic ready,
  input logic accel_en,
  input logic card_scl_pull,
  input logic card_hi,
  input logic en_rise
);
  assert_pull_unlinked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    card_scl_pull |-> (!ready && !accel_en));
  assert_enable_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ready && !card_scl_pull));
  assert_power_loss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (!ready && !card_scl_pull && !accel_en));
  assert_link_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(card_hi) || $past(en_rise)));
endmodule

bind hs_bus_guard hs_bus_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .enable(enable), .ready(ready),
  .accel_en(accel_en), .card_scl_pull(card_scl_pull), .card_hi(card_hi),
  .en_rise(en_rise)
);

// File: tb/tb_hs_bus_guard.sv
module tb_hs_bus_guard;
  localparam int IDLE = 20, STUCK = 400, GAP = 10, HALF = 6, NP = 16;

  logic clk = 0, rst_n = 0, pwr_ok = 0, enable = 0;
  logic bp_sda = 1, bp_scl = 1, dev_sda = 1, dev_scl = 1;
  logic bridge_on, ready, accel_en, card_scl_pull;
  wire card_sda = dev_sda;
  wire card_scl = dev_scl & ~card_scl_pull;
  int compared = 0, mismatched = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hs_bus_guard #(.IDLE_CYC(IDLE), .STUCK_CYC(STUCK), .GAP_CYC(GAP),
                 .HALF_CYC(HALF), .NPULSE(NP)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .enable(enable),
    .bp_sda(bp_sda), .bp_scl(bp_scl), .card_sda(card_sda), .card_scl(card_scl),
    .bridge_on(bridge_on), .ready(ready), .accel_en(accel_en),
    .card_scl_pull(card_scl_pull));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(input int lim, output int took);
    took = 0;
    while (!ready && took < lim) begin tick(1); took++; end
  endtask

  task automatic count_rises(input int n, output int rises);
    logic p = card_scl_pull;
    rises = 0;
    repeat (n) begin
      tick(1);
      if (card_scl_pull && !p) rises++;
      p = card_scl_pull;
    end
  endtask

  task automatic power_cycle();
    pwr_ok = 0; tick(5); pwr_ok = 1;
  endtask

  task automatic stall_and_sweep(input int k);
    int took, t_drop, t_rise, w, extra, seen;
    wait_ready(IDLE + 40, took);
    chk(ready == 1, "R9 relink", ready, 1);
    dev_sda = 0;
    tick(STUCK - 8);
    chk(ready == 1, "R6 still linked before timeout", ready, 1);
    took = 0;
    while (ready && took < 30) begin tick(1); took++; end
    chk(ready == 0, "R6 timeout drop", ready, 0);
    t_drop = cyc;
    took = 0;
    while (!card_scl_pull && took < GAP + 20) begin
      chk(accel_en == 0, "R7 accel off", accel_en, 0);
      tick(1); took++;
    end
    t_rise = cyc;
    chk(t_rise - t_drop == GAP, "R7 gap length", t_rise - t_drop, GAP);
    seen = 1;
    w = 0;
    while (card_scl_pull) begin tick(1); w++; end
    chk(w == HALF, "R7 pulse width", w, HALF);
    while (seen < k) begin
      while (!card_scl_pull) tick(1);
      chk(ready == 0 && accel_en == 0, "R7 link off in burst", ready, 0);
      seen++;
      while (card_scl_pull) tick(1);
    end
    dev_sda = 1;
    count_rises(3 * HALF, extra);
    chk(extra == 0, "R8 early stop pulses", seen + extra, k);
    chk(card_scl_pull == 0, "R8 released at end", card_scl_pull, 0);
  endtask

  initial begin
    int took, r;
    tick(3);
    chk(ready == 0 && bridge_on == 0 && accel_en == 0 && card_scl_pull == 0,
        "R1 reset state", ready, 0);
    rst_n = 1; enable = 1;
    tick(5);
    chk(ready == 0 && card_scl_pull == 0, "R1 power low", ready, 0);

    pwr_ok = 1;
    tick(IDLE - 3);
    chk(ready == 0, "R2 not before idle", ready, 0);
    wait_ready(10, took);
    chk(ready == 1, "R2 idle connect", ready, 1);
    chk(bridge_on == 1 && accel_en == 1, "R5 outputs follow link", accel_en, 1);

    pwr_ok = 0; bp_sda = 0; tick(5); pwr_ok = 1;
    tick(50);
    chk(ready == 0, "R3 busy input blocks", ready, 0);
    bp_sda = 1;
    wait_ready(6, took);
    chk(ready == 1 && took < 6, "R3 stop connect", took, 5);

    pwr_ok = 0; dev_scl = 0; tick(5); pwr_ok = 1;
    tick(60);
    chk(ready == 0, "R4 card low blocks", ready, 0);
    dev_scl = 1;
    wait_ready(6, took);
    chk(ready == 1 && took < 6, "R4 connect on release", took, 5);

    enable = 0; tick(1);
    chk(ready == 0 && accel_en == 0 && bridge_on == 0, "R11 enable low", ready, 0);
    tick(5); enable = 1; tick(5);
    chk(ready == 0, "R2 enable edge waits idle", ready, 0);

    for (int k = 1; k <= NP; k++) stall_and_sweep(k);

    wait_ready(IDLE + 40, took);
    dev_sda = 0;
    count_rises(STUCK + GAP + 2 * HALF * NP + 40, r);
    chk(r == NP, "R7 full burst count", r, NP);
    chk(card_scl_pull == 0, "R8 released after full burst", card_scl_pull, 0);
    count_rises(STUCK - 60, r);
    chk(r == 0 && ready == 0, "R9 still stuck no link", r, 0);
    count_rises(GAP + 60, r);
    chk(r > 0, "R9 second burst", r, 1);

    enable = 0; tick(1);
    chk(card_scl_pull == 0 && ready == 0, "R11 burst stopped", card_scl_pull, 0);
    count_rises(40, r);
    chk(r == 0, "R11 no clocking", r, 0);
    enable = 1;
    tick(2);
    chk(ready == 1, "R12 forced link", ready, 1);
    tick(STUCK - 12);
    chk(ready == 1, "R12 timer restarted", ready, 1);
    took = 0;
    while (ready && took < 30) begin tick(1); took++; end
    chk(ready == 0, "R12 timer armed", ready, 0);
    dev_sda = 1;
    wait_ready(4 * HALF * NP + GAP + 60, took);
    chk(ready == 1, "R9 relink after release", ready, 1);

    pwr_ok = 0; dev_sda = 0; tick(10); pwr_ok = 1;
    count_rises(STUCK - 5, r);
    chk(r == 0 && ready == 0, "R10 no link no pulse", r, 0);
    count_rises(GAP + 30, r);
    chk(r > 0 && ready == 0, "R10 clocking starts", r, 1);
    dev_sda = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 20);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule